// File: doc/BRIEF.md
# Three-Stage Pipeline Flush Controller

This block steers the program counter and per-slot validity through a short integer pipeline. The pipeline has a merged fetch/decode slot, an execute slot and a write-back slot. Fetch always runs to the next sequential instruction. The execute stage resolves every control transfer and reports a taken result on one input, together with the destination address. On a taken result the controller sends fetch to the destination in the next cycle. It also clears the valid bits of the two younger instructions already in flight, so they drain as bubbles.

A not-taken transfer costs nothing. A taken branch or jump always costs exactly two slots. The write-back slot carries a flush qualifier, so downstream register and memory writes can be suppressed for bubbles.

When the instruction source is not ready, fetch and the fetch/decode slot hold, and the execute slot receives a bubble. A redirect that arrives during such a stall is saved and applied on the first ready cycle.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: While reset is high, at the next clock edge `imem_addr` equals `RESET_VEC` (default 0x100). At that point `fd_valid`, `ex_valid` and `wb_valid` are 0 and `wb_flush` is 1.
- R2: With `fetch_rdy` high and no redirect, `imem_addr` rises by 4 every cycle. The address fetched in one cycle appears as `fd_pc` one cycle later, as `ex_pc` two cycles later and as `wb_pc` three cycles later, each with its valid bit set.
- R3: While `ex_taken` is low, no slot is invalidated, and a valid execute instruction arrives valid in write-back one cycle later.
- R4: When `ex_taken` is high while `ex_valid` is high, after the next edge three things hold. `imem_addr` equals `ex_target`. `fd_valid` and `ex_valid` are 0. The transfer's own PC is in write-back with `wb_valid` high. This applies to conditional branches and jumps alike.
- R5: The destination instruction is valid in fetch/decode two cycles after the transfer was in execute. The two killed slots reach write-back on consecutive cycles with `wb_flush` high.
- R6: `wb_flush` is 1 exactly when `wb_valid` is 0.
- R7: `ex_taken` is ignored while `ex_valid` is 0: fetch continues sequentially and fetch/decode stays valid.
- R8: While `fetch_rdy` is low, `imem_addr`, `fd_pc` and `fd_valid` hold, and the execute slot receives a bubble. After `fetch_rdy` returns, the held instruction moves on valid.
- R9: A taken transfer seen while `fetch_rdy` is low is kept. On the first ready cycle `imem_addr` becomes the saved destination, and the stale instruction fetched during the stall enters fetch/decode invalid. One cycle later the destination is valid in fetch/decode.
- R10: If the destination instruction is itself a taken transfer, the kill window restarts. Fetch moves to the newer destination and both younger slots are cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rdy | input | 1 | Instruction source accepts/returns the current fetch |
| ex_taken | input | 1 | Execute stage reports a taken control transfer |
| ex_target | input | 32 | Destination address of the taken transfer |
| imem_addr | output | 32 | Current fetch address to instruction memory |
| next_pc | output | 32 | Address fetch will move to on the next ready cycle |
| fd_pc | output | 32 | PC held in the fetch/decode slot |
| fd_valid | output | 1 | Fetch/decode slot holds a live instruction |
| ex_pc | output | 32 | PC held in the execute slot |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| wb_pc | output | 32 | PC held in the write-back slot |
| wb_valid | output | 1 | Write-back slot holds a live instruction |
| wb_flush | output | 1 | Suppress write-back updates for this slot |

## Verification
Some rules are checked on every cycle. They are:
- the clearing of both younger slots after a qualified redirect;
- fetch landing on the destination, or on a saved destination;
- a held fetch address and held fetch/decode PC during a stall;
- a bubble in execute becoming a flushed write-back;
- a taken flag being ignored on a bubble.

Other behaviour only the directed scenarios can show, because it depends on end-to-end ordering over several cycles. This covers the exact cycle in which the destination becomes valid, the two-cycle flush train, stall then resume, and a taken transfer whose destination is itself taken.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int unsigned PC_W       = 32;
    localparam int unsigned INSN_BYTES = 4;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        pc_t  pc;
        logic valid;
    } slot_t;

    function automatic pc_t seq_pc(input pc_t p);
        return p + pc_t'(INSN_BYTES);
    endfunction

    function automatic slot_t make_bubble(input pc_t p);
        slot_t s;
        s.pc    = p;
        s.valid = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/pfc_fetch.sv
module pfc_fetch
    import pfc_pkg::*;
#(
    parameter pc_t RESET_VEC = pc_t'(32'h100)
) (
    input  logic clk,
    input  logic rst,
    input  logic fetch_rdy,
    input  logic redirect,
    input  pc_t  target,
    output pc_t  fetch_pc,
    output pc_t  next_pc,
    output logic pend_valid
);
    pc_t pend_addr;

    always_comb begin
        if (redirect)
            next_pc = target;
        else if (pend_valid)
            next_pc = pend_addr;
        else
            next_pc = seq_pc(fetch_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc   <= RESET_VEC;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else if (fetch_rdy) begin
            fetch_pc   <= next_pc;
            pend_valid <= 1'b0;
        end else if (redirect) begin
            pend_valid <= 1'b1;
            pend_addr  <= target;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_rdy |=> $stable(fetch_pc));

    // R4
    redirect_land_chk: assert property (@(posedge clk) disable iff (rst)
        redirect && fetch_rdy |=> fetch_pc == $past(target));

    // R9
    redirect_save_chk: assert property (@(posedge clk) disable iff (rst)
        redirect && !fetch_rdy |=> pend_valid);

    // R9
    saved_land_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid && !redirect && fetch_rdy |=> fetch_pc == $past(pend_addr));
endmodule

// File: rtl/pfc_stage.sv
module pfc_stage
    import pfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  kill,
    input  slot_t din,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= make_bubble('0);
        end else if (adv) begin
            q.pc    <= din.pc;
            q.valid <= din.valid & ~kill;
        end else begin
            q.valid <= q.valid & ~kill;
        end
    end

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(q.pc));

    // R4
    slot_kill_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> !q.valid);
endmodule

// File: rtl/pipe_flush_ctrl.sv
module pipe_flush_ctrl
    import pfc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_rdy,
    input  logic        ex_taken,
    input  logic [31:0] ex_target,
    output logic [31:0] imem_addr,
    output logic [31:0] next_pc,
    output logic [31:0] fd_pc,
    output logic        fd_valid,
    output logic [31:0] ex_pc,
    output logic        ex_valid,
    output logic [31:0] wb_pc,
    output logic        wb_valid,
    output logic        wb_flush
);
    pc_t   fetch_pc;
    pc_t   nxt;
    logic  pend;
    logic  kill;
    slot_t fd_in, fd_q, ex_in, ex_q, wb_q;

    assign kill = ex_taken & ex_q.valid;

    pfc_fetch #(.RESET_VEC(pc_t'(RESET_VEC))) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .fetch_rdy  (fetch_rdy),
        .redirect   (kill),
        .target     (pc_t'(ex_target)),
        .fetch_pc   (fetch_pc),
        .next_pc    (nxt),
        .pend_valid (pend)
    );

    always_comb begin
        fd_in.pc    = fetch_pc;
        fd_in.valid = 1'b1;
        ex_in       = fetch_rdy ? fd_q : make_bubble(fd_q.pc);
    end

    pfc_stage u_fd (
        .clk (clk), .rst (rst), .adv (fetch_rdy),
        .kill(kill | pend), .din (fd_in), .q (fd_q)
    );

    pfc_stage u_ex (
        .clk (clk), .rst (rst), .adv (1'b1),
        .kill(kill), .din (ex_in), .q (ex_q)
    );

    pfc_stage u_wb (
        .clk (clk), .rst (rst), .adv (1'b1),
        .kill(1'b0), .din (ex_q), .q (wb_q)
    );

    assign imem_addr = 32'(fetch_pc);
    assign next_pc   = 32'(nxt);
    assign fd_pc     = 32'(fd_q.pc);
    assign fd_valid  = fd_q.valid;
    assign ex_pc     = 32'(ex_q.pc);
    assign ex_valid  = ex_q.valid;
    assign wb_pc     = 32'(wb_q.pc);
    assign wb_valid  = wb_q.valid;
    assign wb_flush  = ~wb_q.valid;

    // R4
    young_kill_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> !fd_valid && !ex_valid);

    // R5
    bubble_flush_chk: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |=> wb_flush);

    // R3
    no_taken_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ex_valid && !ex_taken |=> wb_valid);

    // R7
    bubble_taken_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !ex_valid && fetch_rdy && !pend |=> fd_valid);

    // R4
    branch_retire_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> wb_valid && wb_pc == $past(ex_pc));
endmodule

// File: tb/tb_pipe_flush_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctrl;
    localparam logic [31:0] RV = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_rdy = 1'b1;
    logic        ex_taken = 1'b0;
    logic [31:0] ex_target = '0;
    logic [31:0] imem_addr, next_pc, fd_pc, ex_pc, wb_pc;
    logic        fd_valid, ex_valid, wb_valid, wb_flush;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pipe_flush_ctrl #(.RESET_VEC(RV)) dut (
        .clk(clk), .rst(rst), .fetch_rdy(fetch_rdy), .ex_taken(ex_taken),
        .ex_target(ex_target), .imem_addr(imem_addr), .next_pc(next_pc),
        .fd_pc(fd_pc), .fd_valid(fd_valid), .ex_pc(ex_pc), .ex_valid(ex_valid),
        .wb_pc(wb_pc), .wb_valid(wb_valid), .wb_flush(wb_flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    // R1: reset state, then release at a falling edge
    task automatic do_reset();
        rst = 1'b1; fetch_rdy = 1'b1; ex_taken = 1'b0; ex_target = '0;
        step(); step();
        chk("R1", "imem_addr", imem_addr, RV);
        chk("R1", "fd_valid", {31'b0, fd_valid}, 0);
        chk("R1", "ex_valid", {31'b0, ex_valid}, 0);
        chk("R1", "wb_valid", {31'b0, wb_valid}, 0);
        chk("R1", "wb_flush", {31'b0, wb_flush}, 1);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        do_reset();
        step(); step(); step();
        for (int k = 3; k < 8; k++) begin
            chk("R2", "imem_addr", imem_addr, RV + 32'(4*k));
            chk("R2", "fd_pc", fd_pc, RV + 32'(4*(k-1)));
            chk("R2", "ex_pc", ex_pc, RV + 32'(4*(k-2)));
            chk("R2", "wb_pc", wb_pc, RV + 32'(4*(k-3)));
            chk("R3", "all valid", {29'b0, fd_valid, ex_valid, wb_valid}, 32'h7);
            chk("R6", "wb_flush", {31'b0, wb_flush}, 0);
            step();
        end
    endtask

    task automatic t_taken_and_chain();
        logic [31:0] t1, t2;
        t1 = 32'h2000; t2 = 32'h3000;
        do_reset();
        step(); step(); step();
        chk("R4", "branch in ex", ex_pc, RV + 4);
        ex_taken = 1'b1; ex_target = t1;
        step();
        ex_taken = 1'b0;
        chk("R4", "imem_addr", imem_addr, t1);
        chk("R4", "fd_valid", {31'b0, fd_valid}, 0);
        chk("R4", "ex_valid", {31'b0, ex_valid}, 0);
        chk("R4", "wb_pc", wb_pc, RV + 4);
        chk("R4", "wb_valid", {31'b0, wb_valid}, 1);
        // R7: taken flag on a bubble in execute
        ex_taken = 1'b1; ex_target = 32'h7770;
        step();
        ex_taken = 1'b0;
        chk("R5", "fd_pc", fd_pc, t1);
        chk("R5", "fd_valid", {31'b0, fd_valid}, 1);
        chk("R7", "imem_addr sequential", imem_addr, t1 + 4);
        chk("R5", "wb_flush 1st", {31'b0, wb_flush}, 1);
        chk("R6", "wb_valid", {31'b0, wb_valid}, 0);
        step();
        chk("R5", "wb_flush 2nd", {31'b0, wb_flush}, 1);
        chk("R5", "ex_pc", ex_pc, t1);
        chk("R5", "ex_valid", {31'b0, ex_valid}, 1);
        // R10: destination is itself taken
        ex_taken = 1'b1; ex_target = t2;
        step();
        ex_taken = 1'b0;
        chk("R10", "imem_addr", imem_addr, t2);
        chk("R10", "fd_valid", {31'b0, fd_valid}, 0);
        chk("R10", "ex_valid", {31'b0, ex_valid}, 0);
        chk("R10", "wb_pc", wb_pc, t1);
        chk("R6", "wb_flush low", {31'b0, wb_flush}, 0);
        step();
        chk("R10", "fd_pc", fd_pc, t2);
        chk("R10", "fd_valid new", {31'b0, fd_valid}, 1);
    endtask

    task automatic t_stall();
        do_reset();
        step(); step(); step();
        fetch_rdy = 1'b0;
        step();
        chk("R8", "imem hold", imem_addr, RV + 12);
        chk("R8", "fd_pc hold", fd_pc, RV + 8);
        chk("R8", "fd_valid hold", {31'b0, fd_valid}, 1);
        chk("R8", "ex bubble", {31'b0, ex_valid}, 0);
        step();
        chk("R8", "imem hold 2", imem_addr, RV + 12);
        chk("R8", "wb flush", {31'b0, wb_flush}, 1);
        fetch_rdy = 1'b1;
        step();
        chk("R8", "ex resumes", ex_pc, RV + 8);
        chk("R8", "ex valid", {31'b0, ex_valid}, 1);
        chk("R8", "fd next", fd_pc, RV + 12);
        chk("R8", "imem next", imem_addr, RV + 16);
    endtask

    task automatic t_stall_redirect();
        logic [31:0] t;
        t = 32'h4400;
        do_reset();
        step(); step(); step();
        fetch_rdy = 1'b0; ex_taken = 1'b1; ex_target = t;
        step();
        ex_taken = 1'b0; ex_target = '0;
        chk("R9", "imem hold", imem_addr, RV + 12);
        chk("R9", "fd killed", {31'b0, fd_valid}, 0);
        step();
        chk("R9", "imem hold 2", imem_addr, RV + 12);
        fetch_rdy = 1'b1;
        step();
        chk("R9", "imem saved target", imem_addr, t);
        chk("R9", "stale fd invalid", {31'b0, fd_valid}, 0);
        step();
        chk("R9", "fd target", fd_pc, t);
        chk("R9", "fd target valid", {31'b0, fd_valid}, 1);
    endtask

    initial begin
        t_sequential();
        t_taken_and_chain();
        t_stall();
        t_stall_redirect();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule